// File: doc/BRIEF.md
# Transmit Quadlet Queue with Memory Test Mode

This block is a transmit queue between a host processor and a link engine. The host pushes 32-bit quadlets through a small synchronous register port. Each stored entry is 33 bits wide: the 32 data bits plus a marker bit that flags the opening quadlet of a packet. The link engine drains entries one at a time from the head through its own pop strobe. A status word reports whether the queue is full or empty and how many quadlets of room are left, so the host can tell whether a whole packet fits before it starts writing.

For production testing the host can switch the storage into a test mode. In that mode queue operation stops and the storage behaves as a plain RAM. Accesses go to the location held in a self-incrementing address counter. The marker bit written with each word comes from a status-word field. On read-back the stored marker bit is compared with that field, and any difference latches a sticky error flag. The queue pointers are not changed by the test mode. Flushing the queue is done with the synchronous reset.

Top module: `txq_ramtest`

## Requirements
- R1: After reset the status word at offset 30h reads with bit 1 (empty) set, bit 0 (full) clear, bits 2 to 22 zero and bits 23 to 31 equal to the free space (DEPTH, saturated at 511). `fifo_empty` is 1 and `lnk_data` is zero.
- R2: In normal mode a host write to 80h pushes {0, data} and a host write to 84h pushes {1, data}. Each accepted `lnk_pop` loads the oldest entry into `lnk_data`, with the marker bit in bit 32, at the next clock edge. Entries leave in the order they were pushed.
- R3: When DEPTH entries are held, status bit 0 and `fifo_full` are 1, and further pushes are ignored without changing the stored entries or the occupancy.
- R4: A pop while the queue is empty is ignored: `lnk_data` keeps its value and the status stays unchanged.
- R5: Status bits 23 to 31 show DEPTH minus the occupancy, saturated at 511, and are up to date from the edge that accepts a push or pop. A push and a pop in the same cycle leave the occupancy unchanged.
- R6: While status bit 5 (test mode) is 1, link pops and writes to 84h are ignored, and the occupancy and queue contents order are left as they were.
- R7: In test mode a host write to 80h stores {status bit 4, data} at the counter location, and a host read of 80h returns the data bits of that location. Each such access increments the counter, which is shown in status bits 6 upward and wraps from DEPTH-1 to 0. A status write without bit 3 keeps the counter.
- R8: In test mode a read of 80h whose stored marker bit differs from status bit 4 sets status bit 2 (mismatch error). The bit stays set through later matching reads.
- R9: A status write with bits 3 and 5 both set clears the counter and the mismatch error, so the next test access uses location 0. Bit 3 always reads back as 0.
- R10: A status write with bit 5 clear clears the mismatch error and ends test mode, and the counter keeps its value. In normal mode a read of 80h returns zero and pops nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also flushes the queue |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (ignored when hst_wr is set) |
| hst_addr | input | 8 | Host byte offset: 30h status, 80h data, 84h data with marker |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered, valid after the edge sampling hst_rd |
| lnk_pop | input | 1 | Link-side pop request |
| lnk_data | output | 33 | Last popped entry, marker bit in bit 32 |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_empty | output | 1 | Queue holds no entries |

## Verification
The bench builds the block with ADDR_W = 4, which gives 16 entries. At that size it can fill the queue completely, step by step, and check the space field after every push. It can also press a write against the full condition and drain down to the empty condition. The whole address range can be written and read back in test mode, including the counter wrap from 15 to 0, with alternating marker bits so that both matching and mismatching compares occur.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam logic [7:0] OFS_STAT = 8'h30;
    localparam logic [7:0] OFS_DATA = 8'h80;
    localparam logic [7:0] OFS_HEAD = 8'h84;

    localparam int BIT_CLR = 3;
    localparam int BIT_CTL = 4;
    localparam int BIT_TST = 5;

    localparam int FLD_W   = 9;
    localparam int FLD_MAX = (1 << FLD_W) - 1;

    typedef struct packed {
        logic        ctl;
        logic [31:0] data;
    } txq_word_t;

    typedef struct packed {
        logic [8:0] space;
        logic [7:0] rsvd;
        logic [8:0] cnt;
        logic       tst;
        logic       ctl;
        logic       clr;
        logic       cerr;
        logic       empty;
        logic       full;
    } txq_stat_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_STAT,
        ACC_DATA,
        ACC_HEAD
    } txq_acc_e;

    function automatic txq_acc_e txq_decode(input logic [7:0] a);
        case (a)
            OFS_STAT: return ACC_STAT;
            OFS_DATA: return ACC_DATA;
            OFS_HEAD: return ACC_HEAD;
            default:  return ACC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store
    import txq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  txq_word_t         wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output txq_word_t         rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output txq_word_t         rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    txq_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    output logic              push_ok,
    output logic              pop_ok,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W:0]   count,
    output logic              full,
    output logic              empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: a push against a full queue leaves it untouched
    a_r3_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && !pop_req) |=> ($stable(count) && $stable(wr_ptr)));

    // R4: a pop against an empty queue leaves the read side untouched
    a_r4_empty_blocks: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_req) |=> ($stable(rd_ptr) && $stable(count)));

    // R5: occupancy never exceeds the depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R5: simultaneous push and pop keep occupancy
    a_r5_balanced: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> $stable(count));

endmodule

// File: rtl/txq_csr.sv
module txq_csr
    import txq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [7:0]        hst_addr,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    input  logic              full,
    input  logic              empty,
    input  logic [ADDR_W:0]   count,
    input  txq_word_t         tst_word,
    output logic              tst_mode,
    output logic [ADDR_W-1:0] tst_cnt,
    output logic              push_req,
    output txq_word_t         push_word,
    output logic              ram_we,
    output txq_word_t         ram_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;

    txq_acc_e  acc;
    logic      wr_stat, wr_data, wr_head, rd_take, ram_rd, clr_eff;
    logic      ctl_q, cerr_q;
    logic [CW-1:0] space_w;
    txq_stat_t stat;

    assign acc     = txq_decode(hst_addr);
    assign wr_stat = hst_wr && (acc == ACC_STAT);
    assign wr_data = hst_wr && (acc == ACC_DATA);
    assign wr_head = hst_wr && (acc == ACC_HEAD);
    assign rd_take = hst_rd && !hst_wr;
    assign ram_rd  = rd_take && tst_mode && (acc == ACC_DATA);
    assign clr_eff = wr_stat && hst_wdata[BIT_CLR] && hst_wdata[BIT_TST];

    assign push_req  = !tst_mode && (wr_data || wr_head);
    assign push_word = '{ctl: wr_head, data: hst_wdata};
    assign ram_we    = tst_mode && wr_data;
    assign ram_word  = '{ctl: ctl_q, data: hst_wdata};

    assign space_w = CW'(DEPTH) - count;

    always_comb begin
        stat       = '0;
        stat.full  = full;
        stat.empty = empty;
        stat.cerr  = cerr_q;
        stat.clr   = 1'b0;
        stat.ctl   = ctl_q;
        stat.tst   = tst_mode;
        stat.cnt   = FLD_W'(tst_cnt);
        stat.rsvd  = '0;
        stat.space = (int'(space_w) > FLD_MAX) ? FLD_W'(FLD_MAX) : FLD_W'(space_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tst_mode  <= 1'b0;
            ctl_q     <= 1'b0;
            cerr_q    <= 1'b0;
            tst_cnt   <= '0;
            hst_rdata <= '0;
        end else begin
            if (wr_stat) begin
                tst_mode <= hst_wdata[BIT_TST];
                ctl_q    <= hst_wdata[BIT_CTL];
            end
            if (clr_eff) begin
                tst_cnt <= '0;
            end else if (ram_we || ram_rd) begin
                tst_cnt <= tst_cnt + 1'b1;
            end
            if (clr_eff || (wr_stat && !hst_wdata[BIT_TST])) begin
                cerr_q <= 1'b0;
            end else if (ram_rd && (tst_word.ctl != ctl_q)) begin
                cerr_q <= 1'b1;
            end
            if (rd_take) begin
                if (acc == ACC_STAT) hst_rdata <= stat;
                else if (ram_rd)     hst_rdata <= tst_word.data;
                else                 hst_rdata <= '0;
            end
        end
    end

    // R7: every test-mode data access advances the counter by one
    a_r7_cnt_step: assert property (@(posedge clk) disable iff (rst)
        ((ram_we || ram_rd) && !wr_stat) |=> (tst_cnt == $past(tst_cnt) + 1'b1));

    // R8: the mismatch flag is sticky until an explicit clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (cerr_q && !wr_stat) |=> cerr_q);

    // R9: the clear request zeroes counter and flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr_eff |=> (tst_cnt == '0 && !cerr_q));

    // R10: leaving test mode clears the flag
    a_r10_exit_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !hst_wdata[BIT_TST]) |=> (!cerr_q && !tst_mode));

endmodule

// File: rtl/txq_ramtest.sv
module txq_ramtest
    import txq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hst_wr,
    input  logic        hst_rd,
    input  logic [7:0]  hst_addr,
    input  logic [31:0] hst_wdata,
    output logic [31:0] hst_rdata,
    input  logic        lnk_pop,
    output logic [32:0] lnk_data,
    output logic        fifo_full,
    output logic        fifo_empty
);
    logic              tst_mode, push_req, push_ok, pop_ok, ram_we;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr, tst_cnt, waddr;
    logic [ADDR_W:0]   count;
    txq_word_t         push_word, ram_word, wdata, head_word, tst_word, lnk_q;

    txq_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (lnk_pop && !tst_mode),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    txq_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .hst_wr    (hst_wr),
        .hst_rd    (hst_rd),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .hst_rdata (hst_rdata),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .count     (count),
        .tst_word  (tst_word),
        .tst_mode  (tst_mode),
        .tst_cnt   (tst_cnt),
        .push_req  (push_req),
        .push_word (push_word),
        .ram_we    (ram_we),
        .ram_word  (ram_word)
    );

    assign waddr = tst_mode ? tst_cnt  : wr_ptr;
    assign wdata = tst_mode ? ram_word : push_word;

    txq_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .we      (push_ok || ram_we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (rd_ptr),
        .rdata_a (head_word),
        .raddr_b (tst_cnt),
        .rdata_b (tst_word)
    );

    always_ff @(posedge clk) begin
        if (rst)         lnk_q <= '0;
        else if (pop_ok) lnk_q <= head_word;
    end

    assign lnk_data = lnk_q;

    // R6: in test mode the queue pointers do not move
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        tst_mode |=> ($stable(wr_ptr) && $stable(rd_ptr)));

    // R4: the link output only changes on an accepted pop
    a_r4_lnk_hold: assert property (@(posedge clk) disable iff (rst)
        (!lnk_pop || fifo_empty || tst_mode) |=> $stable(lnk_data));

endmodule

// File: tb/txq_ramtest_bench.sv
`timescale 1ns/1ps
module txq_ramtest_bench;
    localparam int AW = 4;
    localparam int DP = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_wr = 1'b0, hst_rd = 1'b0, lnk_pop = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic [32:0] lnk_data;
    logic        fifo_full, fifo_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [32:0] q[$];
    logic [31:0] img[DP];
    bit          imgc[DP];

    always #2.5 clk = ~clk;

    txq_ramtest #(.ADDR_W(AW)) u_txq_ramtest (
        .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .lnk_pop(lnk_pop), .lnk_data(lnk_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] st(input bit full, input bit empty, input bit cerr,
                                       input bit ctl, input bit tst, input int cnt, input int space);
        return (32'(space) << 23) | (32'(cnt) << 6) | (32'(tst) << 5) | (32'(ctl) << 4)
             | (32'(cerr) << 2) | (32'(empty) << 1) | 32'(full);
    endfunction

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_rd = 1'b1; hst_addr = a;
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    task automatic lpop(output logic [32:0] d);
        @(negedge clk);
        lnk_pop = 1'b1;
        @(negedge clk);
        lnk_pop = 1'b0;
        d = lnk_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [32:0] p;
        logic [32:0] e;
        bit c;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hread(8'h30, r);
        chk("R1 status", r, st(0, 1, 0, 0, 0, 0, DP));
        chk("R1 lnk_data", lnk_data, 0);
        chk("R1 empty pin", fifo_empty, 1);

        // R4 pop on empty
        lpop(p);
        chk("R4 pop empty data", p, 0);
        hread(8'h30, r);
        chk("R4 pop empty status", r, st(0, 1, 0, 0, 0, 0, DP));

        // R2/R3/R5 fill sweep
        for (int i = 0; i < DP; i++) begin
            e = {1'(i % 4 == 0), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101)};
            hwrite(e[32] ? 8'h84 : 8'h80, e[31:0]);
            q.push_back(e);
            hread(8'h30, r);
            chk("R5 space on fill", r, st(i == DP-1, 0, 0, 0, 0, 0, DP-1-i));
        end
        chk("R3 full pin", fifo_full, 1);

        // R3 push while full ignored
        hwrite(8'h80, 32'hDEAD_BEEF);
        hread(8'h30, r);
        chk("R3 overflow ignored", r, st(1, 0, 0, 0, 0, 0, 0));

        // R2 ordered pops
        for (int i = 0; i < 3; i++) begin
            lpop(p);
            chk("R2 pop order", p, q.pop_front());
        end
        hread(8'h30, r);
        chk("R5 space after pops", r, st(0, 0, 0, 0, 0, 0, 3));

        // R5 simultaneous push and pop
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = 8'h84; hst_wdata = 32'h1234_5678; lnk_pop = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0; lnk_pop = 1'b0;
        chk("R5 simultaneous pop data", lnk_data, q.pop_front());
        q.push_back({1'b1, 32'h1234_5678});
        hread(8'h30, r);
        chk("R5 simultaneous space", r, st(0, 0, 0, 0, 0, 0, 3));

        // R2 drain
        while (q.size() > 0) begin
            lpop(p);
            chk("R2 drain order", p, q.pop_front());
        end
        e = p;
        lpop(p);
        chk("R4 pop after drain holds", p, e);
        chk("R4 empty pin", fifo_empty, 1);

        // R6 test mode blocks queue operations
        hwrite(8'h80, 32'h0000_0AAA);
        hwrite(8'h84, 32'h0000_0BBB);
        hwrite(8'h30, 32'h20);
        hread(8'h30, r);
        chk("R6 enter test", r, st(0, 0, 0, 0, 1, 0, DP-2));
        lpop(p);
        chk("R6 pop ignored data", p, e);
        hwrite(8'h84, 32'h0000_0CCC);
        hread(8'h30, r);
        chk("R6 ops ignored status", r, st(0, 0, 0, 0, 1, 0, DP-2));

        // R7 write sweep with wrap
        hwrite(8'h30, 32'h28);
        for (int i = 0; i < DP; i++) begin
            c = 1'(i & 1);
            img[i] = 32'h1000_0000 + 32'(i) * 32'd7777;
            imgc[i] = c;
            hwrite(8'h30, 32'h20 | (32'(c) << 4));
            hwrite(8'h80, img[i]);
            hread(8'h30, r);
            chk("R7 cnt after write", r, st(0, 0, 0, c, 1, (i+1) % DP, DP-2));
        end

        // R7/R8 read sweep, matching marker
        for (int i = 0; i < DP; i++) begin
            hwrite(8'h30, 32'h20 | (32'(imgc[i]) << 4));
            hread(8'h80, r);
            chk("R7 readback data", r, img[i]);
            hread(8'h30, r);
            chk("R8 no mismatch", r, st(0, 0, 0, imgc[i], 1, (i+1) % DP, DP-2));
        end

        // R8 mismatch then sticky
        hwrite(8'h30, 32'h20 | (32'(!imgc[0]) << 4));
        hread(8'h80, r);
        chk("R8 mismatch data", r, img[0]);
        hread(8'h30, r);
        chk("R8 mismatch flag", r, st(0, 0, 1, !imgc[0], 1, 1, DP-2));
        hwrite(8'h30, 32'h20 | (32'(imgc[1]) << 4));
        hread(8'h80, r);
        hread(8'h30, r);
        chk("R8 sticky", r, st(0, 0, 1, imgc[1], 1, 2, DP-2));

        // R9 clear
        hwrite(8'h30, 32'h38);
        hread(8'h30, r);
        chk("R9 clear status", r, st(0, 0, 0, 1, 1, 0, DP-2));
        hread(8'h80, r);
        chk("R9 location zero", r, img[0]);

        // R10 leave test mode
        hwrite(8'h30, 32'h10);
        hread(8'h30, r);
        chk("R10 exit status", r, st(0, 0, 0, 1, 0, 1, DP-2));
        hread(8'h80, r);
        chk("R10 normal data read", r, 0);
        hread(8'h30, r);
        chk("R10 no pop on read", r, st(0, 0, 0, 1, 0, 1, DP-2));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule